// File: doc/BRIEF.md
# In-Order Retirement with Interrupt Boundary Stop

This block sits at the head of a reorder buffer and decides, each cycle, how many of the oldest micro-ops leave the machine. It looks at a window of up to `W` head entries. Each entry has a valid flag, a completed flag, a flag that marks the last micro-op of an architectural instruction, and a small field that gives how many architectural instructions that entry finishes. A plain micro-op in the middle of an instruction carries zero. An ordinary final micro-op carries one. A fused compare-and-branch micro-op carries two.

When no interrupt is waiting, retire slots are filled with completed micro-ops in order, with no regard to where instructions begin or end. When an interrupt request has been seen, retirement continues in order only until a micro-op that closes an instruction retires. In that same cycle the block raises a one-cycle take pulse, and no younger micro-op retires in that cycle. The ROB pops `ret_uops` entries at the clock edge. Two registered running totals accumulate the retired micro-ops and the retired instructions.

Top module: `boundary_retire`

## Requirements
- R1: Entries retire strictly in slot order. `ret_uops` equals the number of leading window slots that are both valid and completed, so retirement stops at the first slot that is invalid or not completed.
- R2: With no interrupt waiting, up to `W` (default 4) completed entries retire in one cycle, whatever their end-of-instruction flags are.
- R3: `ret_insts` equals the sum of the instruction-count fields of the entries retired in that cycle. A fused entry with count 2 adds two while using one slot.
- R4: A one-cycle pulse on `irq_req` is remembered as pending until an interrupt is taken. While it is pending and no instruction boundary has retired, `irq_take` stays low.
- R5: While an interrupt is pending (remembered or requested this cycle), retirement stops just after the first retired entry whose end-of-instruction flag is 1, and `irq_take` is 1 in that cycle.
- R6: While pending, if no retired entry closes an instruction, all ready leading entries still retire and the interrupt stays pending into later cycles.
- R7: If `irq_req` arrives in a cycle where the head entry is valid, completed and closes an instruction, that entry alone retires and `irq_take` is 1 in that same cycle.
- R8: `irq_take` lasts one cycle per taken interrupt. After it, nothing is pending, and `irq_take` stays 0 until a new request arrives.
- R9: `uop_total` and `inst_total` each increase at every clock edge by that cycle's `ret_uops` and `ret_insts`. A synchronous active-high reset clears both totals and any pending interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_valid | input | W | Window slot holds an entry (slot 0 is oldest) |
| win_done | input | W | Slot's micro-op has completed execution |
| win_eoi | input | W | Slot's micro-op is the last of its instruction |
| win_icnt | input | W*ICW | Instructions completed by each slot, ICW bits per slot, slot i at bits i*ICW |
| irq_req | input | 1 | Interrupt request pulse |
| ret_uops | output | CNTW | Micro-ops retired this cycle; the ROB pops this many |
| ret_insts | output | ISUMW | Architectural instructions retired this cycle |
| irq_take | output | 1 | Interrupt taken at the boundary retired this cycle |
| uop_total | output | TOTW | Running total of retired micro-ops |
| inst_total | output | TOTW | Running total of retired instructions |

## Verification
The interesting overlap is the retirement of a boundary micro-op and the taking of the interrupt in the same cycle. The sharpest form of it is a request that arrives on the very cycle a completed single-micro-op instruction sits at the head. The bench builds this case on purpose by emptying its ROB and pushing a completed boundary entry at the head while it pulses the request. It also lets random request pulses land on windows that hold multi-micro-op instructions in all states of completion. In every cycle a behavioural queue model predicts how many entries pop, the instruction count, and whether the interrupt is taken. It judges that the design cut retirement exactly after the boundary and pulsed the take signal in that cycle, not earlier and not later.

// File: rtl/retire_pkg.sv
package retire_pkg;
  localparam int unsigned DEF_WIDTH   = 4;
  localparam int unsigned DEF_ICNT_W  = 2;
  localparam int unsigned DEF_TOTAL_W = 32;

  function automatic int unsigned cnt_bits(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/rtu_scan.sv
module rtu_scan #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] valid,
  input  logic [W-1:0] done,
  input  logic [W-1:0] eoi,
  input  logic         pend_eff,
  output logic [W-1:0] ret_mask,
  output logic         boundary_hit
);
  logic [W:0] go;
  assign go[0] = 1'b1;

  for (genvar i = 0; i < W; i++) begin : g_slot
    assign ret_mask[i] = go[i] & valid[i] & done[i];
    assign go[i+1]     = ret_mask[i] & ~(pend_eff & eoi[i]);
  end

  assign boundary_hit = pend_eff & |(ret_mask & eoi);
endmodule

// File: rtl/rtu_tally.sv
module rtu_tally #(
  parameter int unsigned W     = 4,
  parameter int unsigned ICW   = 2,
  parameter int unsigned CNTW  = 3,
  parameter int unsigned ISUMW = 4
) (
  input  logic [W-1:0]     ret_mask,
  input  logic [W*ICW-1:0] icnt,
  output logic [CNTW-1:0]  uops,
  output logic [ISUMW-1:0] insts
);
  logic [ICW-1:0] masked [W];

  for (genvar i = 0; i < W; i++) begin : g_mask
    assign masked[i] = ret_mask[i] ? icnt[i*ICW +: ICW] : '0;
  end

  always_comb begin
    uops  = '0;
    insts = '0;
    for (int i = 0; i < W; i++) begin
      uops  = uops + CNTW'(ret_mask[i]);
      insts = insts + ISUMW'(masked[i]);
    end
  end
endmodule

// File: rtl/rtu_pending.sv
module rtu_pending (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic take,
  output logic pend_q
);
  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= (pend_q | req) & ~take;
  end
endmodule

// File: rtl/rtu_totals.sv
module rtu_totals #(
  parameter int unsigned CNTW  = 3,
  parameter int unsigned ISUMW = 4,
  parameter int unsigned TOTW  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNTW-1:0]  add_u,
  input  logic [ISUMW-1:0] add_i,
  output logic [TOTW-1:0]  uop_total,
  output logic [TOTW-1:0]  inst_total
);
  always_ff @(posedge clk) begin
    if (rst) begin
      uop_total  <= '0;
      inst_total <= '0;
    end else begin
      uop_total  <= uop_total + TOTW'(add_u);
      inst_total <= inst_total + TOTW'(add_i);
    end
  end
endmodule

// File: rtl/boundary_retire.sv
module boundary_retire
  import retire_pkg::*;
#(
  parameter int unsigned W     = DEF_WIDTH,
  parameter int unsigned ICW   = DEF_ICNT_W,
  parameter int unsigned TOTW  = DEF_TOTAL_W,
  localparam int unsigned CNTW  = cnt_bits(W),
  localparam int unsigned ISUMW = cnt_bits(W * ((1 << ICW) - 1))
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     win_valid,
  input  logic [W-1:0]     win_done,
  input  logic [W-1:0]     win_eoi,
  input  logic [W*ICW-1:0] win_icnt,
  input  logic             irq_req,
  output logic [CNTW-1:0]  ret_uops,
  output logic [ISUMW-1:0] ret_insts,
  output logic             irq_take,
  output logic [TOTW-1:0]  uop_total,
  output logic [TOTW-1:0]  inst_total
);
  logic         pend_q;
  logic         pend_eff;
  logic [W-1:0] ret_mask;

  assign pend_eff = pend_q | irq_req;

  rtu_pending u_pend (
    .clk    (clk),
    .rst    (rst),
    .req    (irq_req),
    .take   (irq_take),
    .pend_q (pend_q)
  );

  rtu_scan #(.W(W)) u_scan (
    .valid        (win_valid),
    .done         (win_done),
    .eoi          (win_eoi),
    .pend_eff     (pend_eff),
    .ret_mask     (ret_mask),
    .boundary_hit (irq_take)
  );

  rtu_tally #(.W(W), .ICW(ICW), .CNTW(CNTW), .ISUMW(ISUMW)) u_tally (
    .ret_mask (ret_mask),
    .icnt     (win_icnt),
    .uops     (ret_uops),
    .insts    (ret_insts)
  );

  rtu_totals #(.CNTW(CNTW), .ISUMW(ISUMW), .TOTW(TOTW)) u_tot (
    .clk        (clk),
    .rst        (rst),
    .add_u      (ret_uops),
    .add_i      (ret_insts),
    .uop_total  (uop_total),
    .inst_total (inst_total)
  );
endmodule

// File: rtl/boundary_retire_chk.sv
module boundary_retire_chk #(
  parameter int unsigned W     = 4,
  parameter int unsigned CNTW  = 3,
  parameter int unsigned ISUMW = 4,
  parameter int unsigned TOTW  = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [W-1:0]     win_valid,
  input logic [W-1:0]     win_done,
  input logic [W-1:0]     win_eoi,
  input logic             irq_req,
  input logic             pend_q,
  input logic [CNTW-1:0]  ret_uops,
  input logic [ISUMW-1:0] ret_insts,
  input logic             irq_take,
  input logic [TOTW-1:0]  uop_total,
  input logic [TOTW-1:0]  inst_total
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  // R1: when no interrupt is taken, the slot after the last retired one is not ready
  assert_stop_at_unready_R1: assert property (@(posedge clk) disable iff (rst)
    (!irq_take && ret_uops < CNTW'(W)) |->
      ((((win_valid & win_done) >> ret_uops) & ONE) == '0));

  // R5: a take always follows a retired instruction boundary as the youngest retired slot
  assert_take_on_boundary_R5: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> (ret_uops != '0) && (((win_eoi >> (ret_uops - CNTW'(1))) & ONE) != '0));

  // R4: no take without a remembered or fresh request
  assert_take_needs_request_R4: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> (irq_req || pend_q));

  // R8: the pending state is gone after a take
  assert_clear_after_take_R8: assert property (@(posedge clk) disable iff (rst)
    irq_take |=> !pend_q);

  // R9: totals follow the per-cycle counts
  assert_uop_total_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> uop_total == $past(uop_total) + TOTW'($past(ret_uops)));

  assert_inst_total_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> inst_total == $past(inst_total) + TOTW'($past(ret_insts)));
endmodule

bind boundary_retire boundary_retire_chk #(
  .W(W), .CNTW(CNTW), .ISUMW(ISUMW), .TOTW(TOTW)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .win_valid  (win_valid),
  .win_done   (win_done),
  .win_eoi    (win_eoi),
  .irq_req    (irq_req),
  .pend_q     (pend_q),
  .ret_uops   (ret_uops),
  .ret_insts  (ret_insts),
  .irq_take   (irq_take),
  .uop_total  (uop_total),
  .inst_total (inst_total)
);

// File: tb/boundary_retire_test.sv
`timescale 1ns/1ps
module boundary_retire_test;
  localparam int W = 4;
  localparam int ICW = 2;
  localparam int TOTW = 32;
  localparam int CNTW = 3;
  localparam int ISUMW = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst;
  logic [W-1:0]     win_valid, win_done, win_eoi;
  logic [W*ICW-1:0] win_icnt;
  logic             irq_req;
  logic [CNTW-1:0]  ret_uops;
  logic [ISUMW-1:0] ret_insts;
  logic             irq_take;
  logic [TOTW-1:0]  uop_total, inst_total;

  boundary_retire #(.W(W), .ICW(ICW), .TOTW(TOTW)) uut (
    .clk(clk), .rst(rst), .win_valid(win_valid), .win_done(win_done),
    .win_eoi(win_eoi), .win_icnt(win_icnt), .irq_req(irq_req),
    .ret_uops(ret_uops), .ret_insts(ret_insts), .irq_take(irq_take),
    .uop_total(uop_total), .inst_total(inst_total)
  );

  typedef struct { bit eoi; int icnt; bit done; } ent_t;
  ent_t q[$];

  int  checks = 0;
  int  fails  = 0;
  bit  m_pend = 0;
  longint m_utot = 0, m_itot = 0;
  int  p_done = 100;
  bit  finished = 0;

  task automatic chk(string tag, longint act, longint exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic push_entry(bit eoi, int icnt, bit done);
    ent_t e;
    e.eoi = eoi; e.icnt = icnt; e.done = done;
    q.push_back(e);
  endtask

  task automatic push_instr();
    int kind = int'($urandom % 4);
    if (kind == 0) push_entry(1, 1, 0);
    else if (kind == 1) push_entry(1, 2, 0);
    else begin
      int len = 2 + int'($urandom % 2);
      for (int k = 0; k < len - 1; k++) push_entry(0, 0, 0);
      push_entry(1, 1, 0);
    end
  endtask

  task automatic drive_window();
    win_valid = '0; win_done = '0; win_eoi = '0; win_icnt = '0;
    for (int i = 0; i < W; i++) begin
      if (i < q.size()) begin
        win_valid[i] = 1'b1;
        win_done[i]  = q[i].done;
        win_eoi[i]   = q[i].eoi;
        win_icnt[i*ICW +: ICW] = ICW'(q[i].icnt);
      end
    end
  endtask

  // one clock of stimulus, prediction and comparison
  task automatic cycle(bit req, bit complete);
    bit pe, tk;
    int n, ins;
    string t_u, t_t;
    @(negedge clk);
    while (q.size() < 8) push_instr();
    if (complete)
      for (int i = 0; i < q.size(); i++)
        if (!q[i].done && int'($urandom % 100) < p_done) q[i].done = 1;
    drive_window();
    irq_req = req;
    #1;
    pe = m_pend || req; n = 0; ins = 0; tk = 0;
    for (int i = 0; i < W; i++) begin
      if (i >= q.size() || !q[i].done) break;
      n++;
      ins += q[i].icnt;
      if (pe && q[i].eoi) begin tk = 1; break; end
    end
    t_u = pe ? (tk ? "R5" : "R6") : ((n == W) ? "R2" : "R1");
    if (tk && req && !m_pend && n == 1) t_t = "R7";
    else if (tk) t_t = "R5";
    else if (pe) t_t = "R4";
    else t_t = "R8";
    chk(t_u, longint'(ret_uops), n, "ret_uops");
    chk("R3", longint'(ret_insts), ins, "ret_insts");
    chk(t_t, longint'(irq_take), tk, "irq_take");
    chk("R9", longint'(uop_total), m_utot, "uop_total");
    chk("R9", longint'(inst_total), m_itot, "inst_total");
    @(posedge clk);
    for (int k = 0; k < n; k++) void'(q.pop_front());
    m_pend = pe && !tk;
    m_utot += n;
    m_itot += ins;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; irq_req = 0;
    win_valid = '0; win_done = '0; win_eoi = '0; win_icnt = '0;
    @(posedge clk); @(posedge clk);
    m_pend = 0; m_utot = 0; m_itot = 0;
    @(negedge clk);
    rst = 0;
    #1;
    chk("R9", longint'(uop_total), 0, "uop_total after reset");
    chk("R9", longint'(inst_total), 0, "inst_total after reset");
    chk("R8", longint'(irq_take), 0, "irq_take after reset");
  endtask

  initial begin
    rst = 1; irq_req = 0;
    win_valid = '0; win_done = '0; win_eoi = '0; win_icnt = '0;
    do_reset();

    // R2: full-width retirement across boundaries
    p_done = 100;
    for (int c = 0; c < 40; c++) cycle(0, 1);

    // R1, R3: partial completion stalls at first unready slot
    p_done = 45;
    for (int c = 0; c < 200; c++) cycle(0, 1);

    // R4, R5, R6: random interrupt pulses
    p_done = 60;
    for (int c = 0; c < 400; c++) cycle(($urandom % 10) == 0, 1);

    // R9: reset clears a pending request
    q.delete();
    p_done = 0;
    cycle(1, 1);
    cycle(0, 1);
    do_reset();
    p_done = 100;
    cycle(0, 1);

    // R7: request lands with a completed boundary at the head
    q.delete();
    push_entry(1, 1, 1);
    push_entry(0, 0, 1);
    push_entry(1, 1, 1);
    cycle(1, 0);
    cycle(0, 0);

    // fused head entry with fresh request (R3, R7)
    q.delete();
    push_entry(1, 2, 1);
    push_entry(1, 2, 1);
    cycle(1, 0);

    p_done = 100;
    for (int c = 0; c < 200; c++) cycle(($urandom % 3) == 0, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule